// File: doc/BRIEF.md
# Paged Program Counter Unit

This block keeps the fetch position of a small sequencer whose 1024-byte program space is cut into four 256-byte pages. The counter is held as an 8-bit offset and a 2-bit page. A plain step advances the offset only, so straight-line code loops back to the top of the same page rather than running into the next one. The page changes only when a taken branch is signalled. The branch logic sits outside this block and pulses the jump strobe only once it has decided to take the branch.

A separate 2-bit bank register holds the page for the next jump. Loading it has no effect on fetch until a jump occurs. At that jump the bank value becomes the counter's page, and the same value is copied into the page bits of three index pointers. Two of these pointers are used for reads and one for writes. Each pointer's offset byte can be loaded or stepped through its own strobe. Those strobes never touch the pointer's page, so pointer walks also wrap inside their page.

Top module: `paged_pc`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets the fetch address, all three pointer addresses and the bank register to zero. A jump issued after reset therefore lands in page 0.
- R2: When step is high and jump is low at an edge, the offset (fetch_addr[7:0]) increases by one and the page (fetch_addr[9:8]) does not change.
- R3: A step taken at offset 0xFF gives offset 0x00 in the same page.
- R4: A jump sets the offset to jump_target.
- R5: A jump sets the page to the value the bank register held before that edge.
- R6: A bank load without a jump leaves fetch_addr unchanged in that cycle and in later cycles up to the next jump.
- R7: A jump sets the page bits (bits 9:8 of each 10-bit field) of all three pointer addresses to the same page that it gives the fetch address.
- R8: When step and jump are both high at the same edge, the jump wins and the step has no effect.
- R9: ptr_load[i] sets the offset of pointer i to ptr_data. ptr_inc[i] adds one to that offset, wrapping from 0xFF to 0x00. ptr_load[i] wins over ptr_inc[i]. Neither strobe changes the pointer's page or the fetch address. Pointer i is output on ptr_addr[10*i+9 : 10*i].
- R10: When bank_load and jump are both high at the same edge, the jump uses the old bank value and the new value is applied only at a later jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | Advance the offset by one |
| jump | input | 1 | Taken branch: load the offset and commit the page |
| jump_target | input | 8 | Offset for the jump |
| bank_load | input | 1 | Write the bank register |
| bank_value | input | 2 | New bank value |
| ptr_load | input | 3 | Per-pointer offset load strobes |
| ptr_inc | input | 3 | Per-pointer offset increment strobes |
| ptr_data | input | 8 | Offset value for pointer loads |
| fetch_addr | output | 10 | {page, offset} of the program counter |
| ptr_addr | output | 30 | Three {page, offset} pointer addresses, pointer 0 in the low bits |

## Verification
The counter is first stepped from zero and then stepped across offset 0xFF. This separates an offset-only increment from a full 10-bit increment that would carry into page 1. Jumps are issued with and without an earlier bank load, with step held high at the same time, and with a bank load in the same cycle. These cases tell a registered page commit apart from a direct path from bank_value or a step that wins over the jump. The pointers are loaded with 0xFF and then incremented, and load and increment are raised together. This shows the page bits are kept and that load wins over increment.

// File: rtl/paged_pc.sv
module paged_pc #(
  parameter int OFS_W  = 8,
  parameter int PAGE_W = 2,
  parameter int NPTR   = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         step,
  input  logic                         jump,
  input  logic [OFS_W-1:0]             jump_target,
  input  logic                         bank_load,
  input  logic [PAGE_W-1:0]            bank_value,
  input  logic [NPTR-1:0]              ptr_load,
  input  logic [NPTR-1:0]              ptr_inc,
  input  logic [OFS_W-1:0]             ptr_data,
  output logic [OFS_W+PAGE_W-1:0]      fetch_addr,
  output logic [NPTR*(OFS_W+PAGE_W)-1:0] ptr_addr
);
  localparam int AW = OFS_W + PAGE_W;

  logic [OFS_W-1:0]  pc_ofs;
  logic [PAGE_W-1:0] pc_page;
  logic [PAGE_W-1:0] bank;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_ofs  <= '0;
      pc_page <= '0;
      bank    <= '0;
    end else begin
      if (jump) begin
        pc_ofs  <= jump_target;
        pc_page <= bank;
      end else if (step) begin
        pc_ofs  <= pc_ofs + 1'b1;
      end
      if (bank_load) bank <= bank_value;
    end
  end

  assign fetch_addr = {pc_page, pc_ofs};

  for (genvar i = 0; i < NPTR; i++) begin : g_ptr
    logic [OFS_W-1:0]  p_ofs;
    logic [PAGE_W-1:0] p_page;

    always_ff @(posedge clk) begin
      if (rst) begin
        p_ofs  <= '0;
        p_page <= '0;
      end else begin
        if (ptr_load[i])     p_ofs <= ptr_data;
        else if (ptr_inc[i]) p_ofs <= p_ofs + 1'b1;
        if (jump)            p_page <= bank;
      end
    end

    assign ptr_addr[i*AW +: AW] = {p_page, p_ofs};

    a_r7_ptr_page_follows: assert property (@(posedge clk) disable iff (rst)
      jump |=> ptr_addr[i*AW+OFS_W +: PAGE_W] == fetch_addr[AW-1 -: PAGE_W]);
    a_r9_ptr_page_kept: assert property (@(posedge clk) disable iff (rst)
      !jump |=> $stable(ptr_addr[i*AW+OFS_W +: PAGE_W]));
    a_r9_ptr_load: assert property (@(posedge clk) disable iff (rst)
      ptr_load[i] |=> ptr_addr[i*AW +: OFS_W] == $past(ptr_data));
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> fetch_addr == '0 && ptr_addr == '0);
  a_r4_jump_offset: assert property (@(posedge clk) disable iff (rst)
    jump |=> fetch_addr[OFS_W-1:0] == $past(jump_target));
  a_r2_step_keeps_page: assert property (@(posedge clk) disable iff (rst)
    (step && !jump) |=> fetch_addr[OFS_W-1:0] == $past(fetch_addr[OFS_W-1:0]) + 1'b1
                        && $stable(fetch_addr[AW-1 -: PAGE_W]));
  a_r6_page_only_on_jump: assert property (@(posedge clk) disable iff (rst)
    !jump |=> $stable(fetch_addr[AW-1 -: PAGE_W]));
  a_r8_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!jump && !step) |=> $stable(fetch_addr));
endmodule

// File: tb/tb_paged_pc.sv
module tb_paged_pc;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       step = 1'b0, jump = 1'b0, bank_load = 1'b0;
  logic [7:0] jump_target = '0, ptr_data = '0;
  logic [1:0] bank_value = '0;
  logic [2:0] ptr_load = '0, ptr_inc = '0;
  logic [9:0] fetch_addr;
  logic [29:0] ptr_addr;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  paged_pc dut (.clk(clk), .rst(rst), .step(step), .jump(jump), .jump_target(jump_target),
    .bank_load(bank_load), .bank_value(bank_value), .ptr_load(ptr_load), .ptr_inc(ptr_inc),
    .ptr_data(ptr_data), .fetch_addr(fetch_addr), .ptr_addr(ptr_addr));

  task automatic chk(string req, logic [9:0] act, logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%03h expected 0x%03h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    step = 0; jump = 0; bank_load = 0; ptr_load = '0; ptr_inc = '0; rst = 0;
  endtask

  function automatic logic [9:0] ptr(int i);
    return ptr_addr[i*10 +: 10];
  endfunction

  task automatic t_reset();
    rst = 1; cyc();
    chk("R1 fetch", fetch_addr, 10'h000);
    for (int i = 0; i < 3; i++) chk("R1 ptr", ptr(i), 10'h000);
    jump = 1; jump_target = 8'h10; cyc();
    chk("R1 bank zero", fetch_addr, 10'h010);
    for (int i = 0; i < 3; i++) chk("R1 ptr page", ptr(i), 10'h000);
  endtask

  task automatic t_step();
    for (int k = 0; k < 5; k++) begin step = 1; cyc(); end
    chk("R2 step", fetch_addr, 10'h015);
  endtask

  task automatic t_bank_hold();
    bank_load = 1; bank_value = 2'd2; cyc();
    chk("R6 bank load", fetch_addr, 10'h015);
    step = 1; cyc();
    chk("R6 step after bank", fetch_addr, 10'h016);
    cyc();
    chk("R6 idle", fetch_addr, 10'h016);
  endtask

  task automatic t_jump();
    jump = 1; jump_target = 8'hFE; cyc();
    chk("R4 R5 jump", fetch_addr, 10'h2FE);
    for (int i = 0; i < 3; i++) chk("R7 ptr repage", ptr(i), 10'h200);
  endtask

  task automatic t_wrap();
    step = 1; cyc();
    chk("R2 step", fetch_addr, 10'h2FF);
    step = 1; cyc();
    chk("R3 wrap", fetch_addr, 10'h200);
  endtask

  task automatic t_prio();
    step = 1; jump = 1; jump_target = 8'h40; cyc();
    chk("R8 jump wins", fetch_addr, 10'h240);
  endtask

  task automatic t_same_cycle();
    bank_load = 1; bank_value = 2'd3; jump = 1; jump_target = 8'h80; cyc();
    chk("R10 old bank", fetch_addr, 10'h280);
    for (int i = 0; i < 3; i++) chk("R10 ptr old bank", ptr(i), 10'h200);
    jump = 1; jump_target = 8'h81; cyc();
    chk("R10 new bank later", fetch_addr, 10'h381);
    chk("R7 ptr1 page", ptr(1), 10'h300);
  endtask

  task automatic t_ptr();
    ptr_load = 3'b010; ptr_data = 8'hFF; cyc();
    chk("R9 load", ptr(1), 10'h3FF);
    ptr_inc = 3'b010; cyc();
    chk("R9 inc wrap", ptr(1), 10'h300);
    ptr_load = 3'b001; ptr_inc = 3'b001; ptr_data = 8'h12; cyc();
    chk("R9 load wins", ptr(0), 10'h312);
    ptr_inc = 3'b100; cyc();
    chk("R9 inc", ptr(2), 10'h301);
    chk("R9 others kept", ptr(1), 10'h300);
    chk("R9 fetch untouched", fetch_addr, 10'h381);
  endtask

  initial begin
    cyc();
    t_reset();
    t_step();
    t_bank_hold();
    t_jump();
    t_wrap();
    t_prio();
    t_same_cycle();
    t_ptr();
    t_reset();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule